// File: doc/BRIEF.md
# Register Alias Table with Tagged Writeback

This block keeps, for every architectural floating-point register, a stored value and an alias field. The alias field either names the station tag that will produce the register's next value or shows that nothing is pending. An issue stage uses it in two ways. It looks up two source registers, and each lookup returns either a ready value or the pending producer tag. It also renames one destination register to the tag of the station it has just allocated.

Finished results arrive on a single broadcast input that carries a tag and a data word. A register takes the broadcast value only while its alias still names that tag. After that it reads as a plain value until it is renamed again. A register that was renamed to a later producer ignores the broadcast of its older producer. A lookup made in the same cycle as a matching broadcast gets the bus value directly.

Top module: `rat_top`

## Requirements
- R1: After a synchronous active-low reset, every register has no pending producer and holds the value 0.
- R2: A lookup of a register with no pending producer returns ready=1, the stored value, and tag 0. A lookup of a pending register returns ready=0, value 0, and the alias tag. Tag value 0 is a legal producer tag.
- R3: A rename with `ren_en`=1 makes `ren_idx` pending on `ren_tag` from the next cycle on. A lookup in the rename cycle still sees the prior state.
- R4: A valid broadcast whose tag equals a pending register's alias writes `cdb_data` into that register and clears its pending state at the next edge.
- R5: A broadcast has no effect on a register whose alias differs from the broadcast tag, such as a stale older producer. It also has no effect on any register when `cdb_valid`=0.
- R6: Once its pending state is cleared, a register returns its stored value on every lookup until the next rename of that register.
- R7: A lookup of a pending register in a cycle with a valid broadcast of its alias tag returns ready=1 and the broadcast data.
- R8: When a rename and a matching broadcast hit the same register in one cycle, the register becomes pending on the new tag and its value is not written.
- R9: The two lookup ports are independent. Two ports given the same index return identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_idx | input | IDX_W | Register index looked up on port A |
| src_a_ready | output | 1 | Port A value is available |
| src_a_value | output | DATA_W | Port A value (0 when not ready) |
| src_a_tag | output | TAG_W | Port A producer tag (0 when ready) |
| src_b_idx | input | IDX_W | Register index looked up on port B |
| src_b_ready | output | 1 | Port B value is available |
| src_b_value | output | DATA_W | Port B value (0 when not ready) |
| src_b_tag | output | TAG_W | Port B producer tag (0 when ready) |
| ren_en | input | 1 | Rename the destination register this cycle |
| ren_idx | input | IDX_W | Destination register to rename |
| ren_tag | input | TAG_W | Tag of the allocated station |
| cdb_valid | input | 1 | Broadcast present this cycle |
| cdb_tag | input | TAG_W | Tag of the broadcasting station |
| cdb_data | input | DATA_W | Broadcast result |

## Verification
The bench sets up a register that is renamed twice and then broadcasts its older tag. A design that writes back without comparing tags would load the stale value and clear the newer mapping. It also makes a rename and the old producer's broadcast land on one register in one cycle. There, a design that lets writeback win would leave the register ready with a value the newer instruction must not see. Same-cycle lookups cover two cases: a missing bypass reports a tag that is already resolved, and a bypass that ignores `cdb_valid` picks up idle bus data. Producer tag 0 is included to catch designs that mistake tag zero for "no producer".

// File: rtl/rat_pkg.sv
// Package rat_pkg
// Holds the default geometry shared by the alias table and its bench.
// Assumes the producer tag space is separate from the "no producer" state,
// which is held as its own bit.
package rat_pkg;
    parameter int unsigned DEF_NUM_REGS = 8;
    parameter int unsigned DEF_TAG_W    = 3;
    parameter int unsigned DEF_DATA_W   = 32;
endpackage

// File: rtl/rat_entry.sv
// Module rat_entry
// One register slot: stored value, pending bit and alias tag.
// Rename takes priority over a matching broadcast in the same cycle.
// Assumes at most one rename targets this slot per cycle.
module rat_entry #(
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              pend,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);
    logic commit;

    // A broadcast is committed only while the alias still names it
    always_comb commit = cdb_valid && pend && (tag == cdb_tag);

    // State update: reset, then rename, then conditional writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            tag   <= '0;
            value <= '0;
        end else if (ren_hit) begin
            pend <= 1'b1;
            tag  <= ren_tag;
        end else if (commit) begin
            value <= cdb_data;
            pend  <= 1'b0;
        end
    end

    assert_rename_sets_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_hit |=> (pend && tag == $past(ren_tag)));

    assert_match_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_hit && cdb_valid && pend && tag == cdb_tag) |=> (!pend && value == $past(cdb_data)));

    assert_mismatch_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_hit && !(cdb_valid && cdb_tag == tag)) |=> ($stable(value) && $stable(pend) && $stable(tag)));

    assert_rename_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_hit && cdb_valid && pend && tag == cdb_tag) |=> (pend && $stable(value)));
endmodule

// File: rtl/rat_read.sv
// Module rat_read
// One lookup port: selects a slot and forwards a matching broadcast.
// Purely combinational; clk/rst_n only time the local assertion.
module rat_read #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned TAG_W    = 3,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pend_arr [NUM_REGS],
    input  logic [TAG_W-1:0]  tag_arr  [NUM_REGS],
    input  logic [DATA_W-1:0] val_arr  [NUM_REGS],
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              ready,
    output logic [DATA_W-1:0] value,
    output logic [TAG_W-1:0]  tag
);
    logic              sel_pend;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;

    // Pick the addressed slot
    always_comb begin
        sel_pend = pend_arr[idx];
        sel_tag  = tag_arr[idx];
        sel_val  = val_arr[idx];
    end

    // Resolve: stored value, same-cycle bypass, or pending tag
    always_comb begin
        if (!sel_pend) begin
            ready = 1'b1;
            value = sel_val;
            tag   = '0;
        end else if (cdb_valid && cdb_tag == sel_tag) begin
            ready = 1'b1;
            value = cdb_data;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !ready) |-> (tag != cdb_tag));
endmodule

// File: rtl/rat_top.sv
// Module rat_top
// Register alias table: NUM_REGS slots, two lookup ports, one rename
// port and one result broadcast per cycle. Assumes the issue logic never
// hands out a tag that is still live in another slot.
module rat_top #(
    parameter int unsigned NUM_REGS = rat_pkg::DEF_NUM_REGS,
    parameter int unsigned TAG_W    = rat_pkg::DEF_TAG_W,
    parameter int unsigned DATA_W   = rat_pkg::DEF_DATA_W,
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic              src_a_ready,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic              src_b_ready,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              ren_en,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data
);
    logic              pend_arr [NUM_REGS];
    logic [TAG_W-1:0]  tag_arr  [NUM_REGS];
    logic [DATA_W-1:0] val_arr  [NUM_REGS];

    // One slot per register, each decoding its own rename strobe
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic hit;
        always_comb hit = ren_en && (ren_idx == IDX_W'(i));

        rat_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren_hit  (hit),
            .ren_tag  (ren_tag),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_data (cdb_data),
            .pend     (pend_arr[i]),
            .tag      (tag_arr[i]),
            .value    (val_arr[i])
        );
    end

    rat_read #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_read_a (
        .clk(clk), .rst_n(rst_n), .idx(src_a_idx),
        .pend_arr(pend_arr), .tag_arr(tag_arr), .val_arr(val_arr),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .ready(src_a_ready), .value(src_a_value), .tag(src_a_tag)
    );

    rat_read #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_read_b (
        .clk(clk), .rst_n(rst_n), .idx(src_b_idx),
        .pend_arr(pend_arr), .tag_arr(tag_arr), .val_arr(val_arr),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .ready(src_b_ready), .value(src_b_value), .tag(src_b_tag)
    );

    assert_ports_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == src_b_idx) |-> (src_a_ready == src_b_ready &&
                                      src_a_value == src_b_value &&
                                      src_a_tag == src_b_tag));

    assert_after_reset_R1: assert property (@(posedge clk)
        (!rst_n && !ren_en) |=> src_a_ready);
endmodule

// File: tb/rat_top_tb.sv
// Bench for rat_top: a vector table walked by one loop, then directed
// checks for reset and tag value zero.
module rat_top_tb;
    localparam int unsigned NR = 8;
    localparam int unsigned TW = 3;
    localparam int unsigned DW = 32;

    typedef struct packed {
        logic          ren_en;
        logic [2:0]    ren_idx;
        logic [TW-1:0] ren_tag;
        logic          cdb_v;
        logic [TW-1:0] cdb_tag;
        logic [DW-1:0] cdb_data;
        logic [2:0]    a_idx;
        logic          ea_rdy;
        logic [DW-1:0] ea_v;
        logic [2:0]    b_idx;
        logic          eb_rdy;
        logic [DW-1:0] eb_v;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd1,1'b1,32'h0,  3'd2,1'b1,32'h0},  // R1
        '{1'b1,3'd1,3'd5, 1'b0,3'd0,32'h0,  3'd1,1'b1,32'h0,  3'd2,1'b1,32'h0},  // R3 old state
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd1,1'b0,32'd5,  3'd2,1'b1,32'h0},  // R2
        '{1'b0,3'd0,3'd0, 1'b1,3'd5,32'h11, 3'd1,1'b1,32'h11, 3'd2,1'b1,32'h0},  // R7
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd1,1'b1,32'h11, 3'd1,1'b1,32'h11}, // R4 R9
        '{1'b1,3'd3,3'd2, 1'b0,3'd0,32'h0,  3'd3,1'b1,32'h0,  3'd1,1'b1,32'h11}, // R6
        '{1'b1,3'd3,3'd4, 1'b0,3'd0,32'h0,  3'd3,1'b0,32'd2,  3'd3,1'b0,32'd2},
        '{1'b0,3'd0,3'd0, 1'b1,3'd2,32'h22, 3'd3,1'b0,32'd4,  3'd1,1'b1,32'h11}, // R5 stale
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd3,1'b0,32'd4,  3'd3,1'b0,32'd4},  // R5
        '{1'b0,3'd0,3'd0, 1'b1,3'd4,32'h44, 3'd3,1'b1,32'h44, 3'd3,1'b1,32'h44}, // R7
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd3,1'b1,32'h44, 3'd1,1'b1,32'h11}, // R4
        '{1'b1,3'd2,3'd6, 1'b0,3'd0,32'h0,  3'd2,1'b1,32'h0,  3'd3,1'b1,32'h44},
        '{1'b1,3'd2,3'd7, 1'b1,3'd6,32'h66, 3'd2,1'b1,32'h66, 3'd2,1'b1,32'h66}, // R8 cycle
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd2,1'b0,32'd7,  3'd2,1'b0,32'd7},  // R8
        '{1'b0,3'd0,3'd0, 1'b1,3'd7,32'h77, 3'd2,1'b1,32'h77, 3'd4,1'b1,32'h0},
        '{1'b1,3'd4,3'd1, 1'b0,3'd0,32'h0,  3'd2,1'b1,32'h77, 3'd4,1'b1,32'h0},  // R6
        '{1'b0,3'd0,3'd0, 1'b0,3'd1,32'h99, 3'd4,1'b0,32'd1,  3'd4,1'b0,32'd1},  // R5 idle bus
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd4,1'b0,32'd1,  3'd2,1'b1,32'h77}, // R5
        '{1'b1,3'd2,3'd3, 1'b0,3'd0,32'h0,  3'd2,1'b1,32'h77, 3'd4,1'b0,32'd1},  // R6
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,32'h0,  3'd2,1'b0,32'd3,  3'd1,1'b1,32'h11}  // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    src_a_idx = '0, src_b_idx = '0, ren_idx = '0;
    logic          src_a_ready, src_b_ready;
    logic [DW-1:0] src_a_value, src_b_value;
    logic [TW-1:0] src_a_tag, src_b_tag;
    logic          ren_en = 1'b0, cdb_valid = 1'b0;
    logic [TW-1:0] ren_tag = '0, cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    rat_top #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag),
        .ren_en(ren_en), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    // Compare one port against expected ready and value-or-tag
    task automatic chk(input string req, input logic rdy, input logic [DW-1:0] val,
                       input logic [TW-1:0] tg, input logic erdy, input logic [DW-1:0] ev);
        logic ok;
        n_checks++;
        if (erdy) ok = rdy && val == ev && tg == '0;
        else      ok = !rdy && val == '0 && tg == ev[TW-1:0];
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got rdy=%0b val=%h tag=%0d, expected rdy=%0b %s=%h",
                     req, rdy, val, tg, erdy, erdy ? "val" : "tag", ev);
        end
    endtask

    task automatic idle();
        ren_en = 1'b0; cdb_valid = 1'b0; ren_tag = '0; cdb_tag = '0; cdb_data = '0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ren_en = VECS[i].ren_en;  ren_idx = VECS[i].ren_idx; ren_tag = VECS[i].ren_tag;
            cdb_valid = VECS[i].cdb_v; cdb_tag = VECS[i].cdb_tag; cdb_data = VECS[i].cdb_data;
            src_a_idx = VECS[i].a_idx; src_b_idx = VECS[i].b_idx;
            #2;
            chk($sformatf("R2/R3-R9 vec%0d port A", i), src_a_ready, src_a_value, src_a_tag,
                VECS[i].ea_rdy, VECS[i].ea_v);
            chk($sformatf("R2/R3-R9 vec%0d port B", i), src_b_ready, src_b_value, src_b_tag,
                VECS[i].eb_rdy, VECS[i].eb_v);
        end

        // R1: reset clears pending and values
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; src_a_idx = 3'd3; src_b_idx = 3'd2;
        #2;
        chk("R1 reset r3", src_a_ready, src_a_value, src_a_tag, 1'b1, 32'h0);
        chk("R1 reset r2", src_b_ready, src_b_value, src_b_tag, 1'b1, 32'h0);

        // R2: tag zero is a real producer
        @(negedge clk); ren_en = 1'b1; ren_idx = 3'd5; ren_tag = 3'd0;
        @(negedge clk); idle(); src_a_idx = 3'd5; src_b_idx = 3'd6;
        #2;
        chk("R2 tag zero pending", src_a_ready, src_a_value, src_a_tag, 1'b0, 32'd0);
        chk("R2 other reg ready", src_b_ready, src_b_value, src_b_tag, 1'b1, 32'h0);
        @(negedge clk); cdb_valid = 1'b1; cdb_tag = 3'd0; cdb_data = 32'h5A;
        #2;
        chk("R7 tag zero bypass", src_a_ready, src_a_value, src_a_tag, 1'b1, 32'h5A);
        @(negedge clk); idle();
        #2;
        chk("R4 tag zero written", src_a_ready, src_a_value, src_a_tag, 1'b1, 32'h5A);
        chk("R5 r6 untouched", src_b_ready, src_b_value, src_b_tag, 1'b1, 32'h0);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule